// File: doc/BRIEF.md
# Shared Parameter RAM Access Arbiter

This block sits in front of a single-ported parameter RAM and decides, cycle by cycle, which of four clients drives it. There are two execution engines, a host bus port and a coherent transfer unit. The engines do not arbitrate with each other. A free-running slot counter hands each engine its own recurring cycle, so a single access by one engine never delays the other.

The host and the coherent unit each take the RAM exclusively for a window of fixed length. A host window lasts `HOST_CYC` cycles, and the host's own access happens in the first of them. A coherent window is an atomic four-cycle sequence that copies two parameters: read the first source, write the first destination, read the second source, then write the second destination. The unit latches its four addresses when it is accepted. An engine that asks for the RAM during either window sees its stall output high until it is granted in a later slot of its own.

The RAM has a synchronous read, so read data arrives one cycle after the access. In each coherent write cycle, the data just read is written straight back out.

Top module: `prm_arb_top`

## Requirements
- R1: In any cycle at most one of these is active: an engine grant, `host_gnt_o`, or `cpt_busy_o`. `ram_en_o` is high only in such a cycle, and idle cycles leave it low.
- R2: `slot_o` is 0 in the first cycle after reset and then advances by one, modulo the engine count, every clock. Engine e is granted only in a cycle where `slot_o` equals e, it requests, and no host or coherent window is open. In that same cycle its access reaches the RAM with its own write enable, address and write data. For a read, `rdata_o` carries the RAM data one cycle later, with `eng_rvalid_o[e]` high.
- R3: `eng_stall_o[e]` is high exactly in the cycles where engine e requests and is not granted. It changes combinationally in the same cycle.
- R4: When no host or coherent window is open, a requesting engine is granted within the engine-count minus one cycles, whatever the other engine does.
- R5: A host request seen in an idle cycle gets `host_gnt_o` in the following cycle, and the host access takes place in that grant cycle. The host window lasts `HOST_CYC` cycles starting at the grant. Every requesting engine is stalled throughout the window. A host read returns data with `host_rvalid_o` one cycle after the grant.
- R6: If an engine is granted in its slot in the same idle cycle that a host request arrives, the engine access completes in that cycle and the host is granted in the next one.
- R7: When a coherent request is accepted in an idle cycle, `cpt_ack_o` is high in that cycle. In the next four cycles, `cpt_busy_o` is high and the RAM sees, in order: read `src0`, write `dst0`, read `src1`, write `dst1`. Each write stores the data read in the cycle before it. `cpt_done_o` is high in the fourth cycle.
- R8: The four coherent addresses are captured in the `cpt_ack_o` cycle. Changes to those inputs afterwards have no effect on the running sequence.
- R9: Every requesting engine is stalled during all four coherent cycles.
- R10: When a host request and a coherent request are both pending in an idle cycle, the host wins first after reset. After that, the preference flips each time either one is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| eng_req_i | input | NUM_ENG | Engine access request, per engine |
| eng_we_i | input | NUM_ENG | Engine write enable |
| eng_addr_i | input | NUM_ENG*AW | Engine addresses, engine e at bits e*AW |
| eng_wdata_i | input | NUM_ENG*DW | Engine write data, engine e at bits e*DW |
| eng_gnt_o | output | NUM_ENG | Engine access happens this cycle |
| eng_stall_o | output | NUM_ENG | Engine request is blocked this cycle |
| eng_rvalid_o | output | NUM_ENG | Read data for engine is on rdata_o |
| host_req_i | input | 1 | Host access request, held until granted |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | AW | Host address |
| host_wdata_i | input | DW | Host write data |
| host_gnt_o | output | 1 | Host access happens this cycle |
| host_rvalid_o | output | 1 | Read data for host is on rdata_o |
| cpt_req_i | input | 1 | Coherent transfer request |
| cpt_src0_i | input | AW | First parameter source address |
| cpt_dst0_i | input | AW | First parameter destination address |
| cpt_src1_i | input | AW | Second parameter source address |
| cpt_dst1_i | input | AW | Second parameter destination address |
| cpt_ack_o | output | 1 | Transfer accepted, addresses captured |
| cpt_busy_o | output | 1 | Transfer sequence owns the RAM |
| cpt_done_o | output | 1 | Last access of the sequence |
| slot_o | output | SW | Current engine slot |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | AW | RAM address |
| ram_wdata_o | output | DW | RAM write data |
| ram_rdata_i | input | DW | RAM read data, one cycle after a read |
| rdata_o | output | DW | Read data returned to the requester |

## Verification
The bench builds the block with two engines, an 8-bit address, 16-bit data and a two-cycle host window. It models the RAM itself. With two engines the slot simply alternates, so every collision scenario can be lined up on a known slot. That makes it possible to predict exactly which engine is served first when a window closes, and that a stalled engine waits past the window into its next slot. The two-cycle window is short enough to check the stall in every cycle of it. A reset before the preference test fixes the initial host-first order.

// File: rtl/prm_arb_pkg.sv
package prm_arb_pkg;
  typedef enum logic [1:0] {OWN_IDLE, OWN_HOST, OWN_CPT} owner_e;
  localparam logic [1:0] STEP_RD0 = 2'd0;
  localparam logic [1:0] STEP_WR0 = 2'd1;
  localparam logic [1:0] STEP_RD1 = 2'd2;
  localparam logic [1:0] STEP_WR1 = 2'd3;
endpackage

// File: rtl/prm_slot_gen.sv
module prm_slot_gen #(
  parameter int NUM_ENG = 2,
  localparam int SW = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [SW-1:0] slot_o
);
  logic [SW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           slot_q <= '0;
    else if (slot_q == SW'(NUM_ENG - 1))   slot_q <= '0;
    else                                   slot_q <= slot_q + 1'b1;
  end

  assign slot_o = slot_q;

  assert_slot_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q == SW'(NUM_ENG - 1) |=> slot_q == '0);
endmodule

// File: rtl/prm_owner_fsm.sv
module prm_owner_fsm
  import prm_arb_pkg::*;
#(
  parameter int HOST_CYC = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   host_req_i,
  input  logic   cpt_req_i,
  input  logic   cpt_last_i,
  output owner_e owner_o,
  output logic   host_gnt_o,
  output logic   cpt_start_o,
  output logic   host_win_o
);
  localparam int CW = (HOST_CYC > 1) ? $clog2(HOST_CYC) : 1;

  owner_e        own_q;
  logic [CW-1:0] cnt_q;
  logic          pref_host_q;
  logic          pick_host, pick_cpt;

  // equal standing: preference alternates on every exclusive grant
  assign pick_host = (own_q == OWN_IDLE) && host_req_i && (!cpt_req_i || pref_host_q);
  assign pick_cpt  = (own_q == OWN_IDLE) && cpt_req_i && (!host_req_i || !pref_host_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q       <= OWN_IDLE;
      cnt_q       <= '0;
      pref_host_q <= 1'b1;
    end else begin
      case (own_q)
        OWN_IDLE: begin
          if (pick_host) begin
            own_q       <= OWN_HOST;
            cnt_q       <= '0;
            pref_host_q <= 1'b0;
          end else if (pick_cpt) begin
            own_q       <= OWN_CPT;
            pref_host_q <= 1'b1;
          end
        end
        OWN_HOST: begin
          if (cnt_q == CW'(HOST_CYC - 1)) own_q <= OWN_IDLE;
          else                            cnt_q <= cnt_q + 1'b1;
        end
        OWN_CPT: if (cpt_last_i) own_q <= OWN_IDLE;
        default: own_q <= OWN_IDLE;
      endcase
    end
  end

  assign owner_o     = own_q;
  assign host_win_o  = (own_q == OWN_HOST);
  assign host_gnt_o  = (own_q == OWN_HOST) && (cnt_q == '0);
  assign cpt_start_o = pick_cpt;

  assert_host_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == OWN_HOST) && (cnt_q != CW'(HOST_CYC - 1)) |=> own_q == OWN_HOST);

  assert_pref_host_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == OWN_IDLE) && host_req_i && cpt_req_i && pref_host_q |=> host_gnt_o);

  assert_pref_cpt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == OWN_IDLE) && host_req_i && cpt_req_i && !pref_host_q |=> own_q == OWN_CPT);
endmodule

// File: rtl/prm_cpt_seq.sv
module prm_cpt_seq
  import prm_arb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src0_i,
  input  logic [AW-1:0] dst0_i,
  input  logic [AW-1:0] src1_i,
  input  logic [AW-1:0] dst1_i,
  input  logic [DW-1:0] rdata_i,
  output logic          busy_o,
  output logic          last_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  logic          active_q;
  logic [1:0]    step_q;
  logic [AW-1:0] src0_q, dst0_q, src1_q, dst1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      step_q   <= STEP_RD0;
      src0_q   <= '0;
      dst0_q   <= '0;
      src1_q   <= '0;
      dst1_q   <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        step_q   <= STEP_RD0;
        src0_q   <= src0_i;
        dst0_q   <= dst0_i;
        src1_q   <= src1_i;
        dst1_q   <= dst1_i;
      end
    end else begin
      step_q <= step_q + 2'd1;
      if (step_q == STEP_WR1) active_q <= 1'b0;
    end
  end

  always_comb begin
    case (step_q)
      STEP_RD0: addr_o = src0_q;
      STEP_WR0: addr_o = dst0_q;
      STEP_RD1: addr_o = src1_q;
      default:  addr_o = dst1_q;
    endcase
  end

  assign busy_o  = active_q;
  assign last_o  = active_q && (step_q == STEP_WR1);
  assign we_o    = step_q[0];
  assign wdata_o = rdata_i;  // sync-read data from previous step

  assert_step_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && (step_q != STEP_WR1) |=> active_q && (step_q == $past(step_q) + 2'd1));

  assert_atomic_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> $past(active_q) && $past(active_q, 2) && $past(active_q, 3));

  assert_start_rd0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q && start_i |=> active_q && (step_q == STEP_RD0));
endmodule

// File: rtl/prm_arb_top.sv
module prm_arb_top
  import prm_arb_pkg::*;
#(
  parameter int NUM_ENG  = 2,
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int HOST_CYC = 2,
  localparam int SW = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_ENG-1:0]    eng_req_i,
  input  logic [NUM_ENG-1:0]    eng_we_i,
  input  logic [NUM_ENG*AW-1:0] eng_addr_i,
  input  logic [NUM_ENG*DW-1:0] eng_wdata_i,
  output logic [NUM_ENG-1:0]    eng_gnt_o,
  output logic [NUM_ENG-1:0]    eng_stall_o,
  output logic [NUM_ENG-1:0]    eng_rvalid_o,
  input  logic                  host_req_i,
  input  logic                  host_we_i,
  input  logic [AW-1:0]         host_addr_i,
  input  logic [DW-1:0]         host_wdata_i,
  output logic                  host_gnt_o,
  output logic                  host_rvalid_o,
  input  logic                  cpt_req_i,
  input  logic [AW-1:0]         cpt_src0_i,
  input  logic [AW-1:0]         cpt_dst0_i,
  input  logic [AW-1:0]         cpt_src1_i,
  input  logic [AW-1:0]         cpt_dst1_i,
  output logic                  cpt_ack_o,
  output logic                  cpt_busy_o,
  output logic                  cpt_done_o,
  output logic [SW-1:0]         slot_o,
  output logic                  ram_en_o,
  output logic                  ram_we_o,
  output logic [AW-1:0]         ram_addr_o,
  output logic [DW-1:0]         ram_wdata_o,
  input  logic [DW-1:0]         ram_rdata_i,
  output logic [DW-1:0]         rdata_o
);
  owner_e        owner;
  logic          host_gnt, host_win, cpt_start, cpt_last, cpt_busy, cpt_we;
  logic [AW-1:0] cpt_addr;
  logic [DW-1:0] cpt_wdata;
  logic [SW-1:0] slot;
  logic [NUM_ENG-1:0] eng_gnt, eng_rv_q;
  logic          host_rv_q;

  prm_slot_gen #(.NUM_ENG(NUM_ENG)) u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_o(slot));

  prm_owner_fsm #(.HOST_CYC(HOST_CYC)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .host_req_i(host_req_i), .cpt_req_i(cpt_req_i), .cpt_last_i(cpt_last),
    .owner_o(owner), .host_gnt_o(host_gnt), .cpt_start_o(cpt_start),
    .host_win_o(host_win));

  prm_cpt_seq #(.AW(AW), .DW(DW)) u_cpt (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cpt_start),
    .src0_i(cpt_src0_i), .dst0_i(cpt_dst0_i),
    .src1_i(cpt_src1_i), .dst1_i(cpt_dst1_i),
    .rdata_i(ram_rdata_i), .busy_o(cpt_busy), .last_o(cpt_last),
    .we_o(cpt_we), .addr_o(cpt_addr), .wdata_o(cpt_wdata));

  // time-interleaved engine slots
  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    assign eng_gnt[e] = (owner == OWN_IDLE) && eng_req_i[e] && (slot == SW'(e));

    assert_stall_host_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      host_win && eng_req_i[e] |-> eng_stall_o[e]);
    assert_stall_cpt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpt_busy && eng_req_i[e] |-> eng_stall_o[e]);
  end

  always_comb begin
    ram_en_o    = 1'b0;
    ram_we_o    = 1'b0;
    ram_addr_o  = '0;
    ram_wdata_o = '0;
    if (cpt_busy) begin
      ram_en_o    = 1'b1;
      ram_we_o    = cpt_we;
      ram_addr_o  = cpt_addr;
      ram_wdata_o = cpt_wdata;
    end else if (host_gnt) begin
      ram_en_o    = 1'b1;
      ram_we_o    = host_we_i;
      ram_addr_o  = host_addr_i;
      ram_wdata_o = host_wdata_i;
    end else begin
      for (int e = 0; e < NUM_ENG; e++) begin
        if (eng_gnt[e]) begin
          ram_en_o    = 1'b1;
          ram_we_o    = eng_we_i[e];
          ram_addr_o  = eng_addr_i[e*AW +: AW];
          ram_wdata_o = eng_wdata_i[e*DW +: DW];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eng_rv_q  <= '0;
      host_rv_q <= 1'b0;
    end else begin
      eng_rv_q  <= eng_gnt & ~eng_we_i;
      host_rv_q <= host_gnt & ~host_we_i;
    end
  end

  assign eng_gnt_o     = eng_gnt;
  assign eng_stall_o   = eng_req_i & ~eng_gnt;
  assign eng_rvalid_o  = eng_rv_q;
  assign host_gnt_o    = host_gnt;
  assign host_rvalid_o = host_rv_q;
  assign cpt_ack_o     = cpt_start;
  assign cpt_busy_o    = cpt_busy;
  assign cpt_done_o    = cpt_last;
  assign slot_o        = slot;
  assign rdata_o       = ram_rdata_i;

  assert_single_owner_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({eng_gnt, host_gnt, cpt_busy}));

  assert_cpt_owner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpt_busy == (owner == OWN_CPT));

  assert_engine_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eng_gnt) && host_req_i && !cpt_req_i |=> host_gnt);
endmodule

// File: tb/prm_arb_top_tb.sv
`timescale 1ns/1ps
module prm_arb_top_tb;
  localparam int NE = 2, AW = 8, DW = 16;
  localparam int NV = 8;
  // {engine, we, addr, data}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h10, 16'h1111}, {1'b1, 1'b1, 8'h11, 16'h2222},
    {1'b0, 1'b1, 8'h20, 16'hA5A5}, {1'b1, 1'b1, 8'h21, 16'h5A5A},
    {1'b1, 1'b0, 8'h10, 16'h1111}, {1'b0, 1'b0, 8'h11, 16'h2222},
    {1'b0, 1'b0, 8'h21, 16'h5A5A}, {1'b1, 1'b0, 8'h20, 16'hA5A5}};

  logic clk = 0, rst_ni = 0;
  logic [NE-1:0] eng_req = '0, eng_we = '0;
  logic [NE*AW-1:0] eng_addr = '0;
  logic [NE*DW-1:0] eng_wdata = '0;
  logic [NE-1:0] eng_gnt_o, eng_stall_o, eng_rvalid_o;
  logic host_req = 0, host_we = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_gnt_o, host_rvalid_o;
  logic cpt_req = 0;
  logic [AW-1:0] src0 = '0, dst0 = '0, src1 = '0, dst1 = '0;
  logic cpt_ack_o, cpt_busy_o, cpt_done_o;
  logic [0:0] slot_o;
  logic ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata, rdata_o;
  logic [DW-1:0] mem [256];
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (ram_en) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    else        ram_rdata <= mem[ram_addr];
  end

  prm_arb_top #(.NUM_ENG(NE), .AW(AW), .DW(DW), .HOST_CYC(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .eng_req_i(eng_req), .eng_we_i(eng_we), .eng_addr_i(eng_addr), .eng_wdata_i(eng_wdata),
    .eng_gnt_o(eng_gnt_o), .eng_stall_o(eng_stall_o), .eng_rvalid_o(eng_rvalid_o),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_gnt_o(host_gnt_o), .host_rvalid_o(host_rvalid_o),
    .cpt_req_i(cpt_req), .cpt_src0_i(src0), .cpt_dst0_i(dst0),
    .cpt_src1_i(src1), .cpt_dst1_i(dst1),
    .cpt_ack_o(cpt_ack_o), .cpt_busy_o(cpt_busy_o), .cpt_done_o(cpt_done_o),
    .slot_o(slot_o), .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata), .rdata_o(rdata_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk); #1;
  endtask

  task automatic eng_op(input int e, input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd, output int wt);
    @(negedge clk);
    eng_req[e] = 1'b1; eng_we[e] = we;
    eng_addr[e*AW +: AW] = a; eng_wdata[e*DW +: DW] = d;
    wt = 0; rd = '0;
    #1;
    while (!eng_gnt_o[e] && wt < 20) begin
      chk("R3 stall while waiting", eng_stall_o[e], 1);
      wt++;
      nxt();
    end
    chk("R2 engine grant", eng_gnt_o[e], 1);
    chk("R3 no stall on grant", eng_stall_o[e], 0);
    chk("R2 grant in own slot", slot_o, e);
    chk("R1 sole owner", {host_gnt_o, cpt_busy_o}, 0);
    chk("R2 ram enable/we", {ram_en, ram_we}, {1'b1, we});
    chk("R2 ram addr", ram_addr, a);
    if (we) chk("R2 ram wdata", ram_wdata, d);
    @(negedge clk); eng_req[e] = 1'b0; #1;
    if (!we) begin
      chk("R2 read valid", eng_rvalid_o[e], 1);
      rd = rdata_o;
    end
  endtask

  initial begin
    logic [DW-1:0] rd;
    int wt;
    repeat (3) @(negedge clk);
    rst_ni = 1; #1;
    chk("R2 slot after reset", slot_o, 0);
    chk("R1 idle ram", ram_en, 0);
    chk("R3 no stall after reset", eng_stall_o, 0);
    chk("R7 not busy after reset", {cpt_busy_o, cpt_ack_o, host_gnt_o}, 0);
    nxt(); chk("R2 slot advance", slot_o, 1);
    nxt(); chk("R2 slot wrap", slot_o, 0);

    // vector table: interleaved engine traffic
    for (int i = 0; i < NV; i++) begin
      eng_op(int'(VEC[i][25]), VEC[i][24], VEC[i][23:16], VEC[i][15:0], rd, wt);
      chk("R4 wait bounded by slot count", wt <= NE - 1, 1);
      if (!VEC[i][24]) chk("R2 read data", rd, VEC[i][15:0]);
    end

    // engine vs host in same idle cycle, then host window stalls
    nxt();
    while (slot_o != 0) nxt();
    eng_req[0] = 1; eng_we[0] = 1; eng_addr[7:0] = 8'h30; eng_wdata[15:0] = 16'h3333;
    host_req = 1; host_we = 0; host_addr = 8'h10;
    #1;
    chk("R6 engine served first", {eng_gnt_o[0], host_gnt_o}, 2'b10);
    nxt();
    eng_addr[7:0] = 8'h31; eng_wdata[15:0] = 16'h4444;
    eng_req[1] = 1; eng_we[1] = 1; eng_addr[15:8] = 8'h32; eng_wdata[31:16] = 16'h5555;
    #1;
    chk("R6 host next cycle", host_gnt_o, 1);
    chk("R5 host access", {ram_en, ram_we, ram_addr}, {2'b10, 8'h10});
    chk("R5 engines stalled c0", eng_stall_o, 2'b11);
    @(negedge clk); host_req = 0; #1;
    chk("R5 host read data", {host_rvalid_o, rdata_o}, {1'b1, 16'h1111});
    chk("R5 engines stalled c1", eng_stall_o, 2'b11);
    nxt();
    chk("R4 engine1 after window", {eng_gnt_o, eng_stall_o}, 4'b1001);
    chk("R4 engine1 addr", ram_addr, 8'h32);
    @(negedge clk); eng_req[1] = 0; #1;
    chk("R4 engine0 next slot", eng_gnt_o, 2'b01);
    chk("R4 engine0 addr", {ram_addr, ram_wdata}, {8'h31, 16'h4444});
    @(negedge clk); eng_req[0] = 0;

    // coherent transfer
    cpt_req = 1; src0 = 8'h10; dst0 = 8'h40; src1 = 8'h21; dst1 = 8'h41;
    #1;
    chk("R7 ack", cpt_ack_o, 1);
    @(negedge clk);
    cpt_req = 0; src0 = 8'hF0; dst0 = 8'hF1; src1 = 8'hF2; dst1 = 8'hF3;
    eng_req = 2'b11; eng_we = 2'b00;
    #1;
    chk("R7 rd0", {cpt_busy_o, ram_en, ram_we, ram_addr}, {3'b110, 8'h10});
    chk("R8 src0 latched", ram_addr, 8'h10);
    chk("R9 stalled rd0", eng_stall_o, 2'b11);
    nxt();
    chk("R7 wr0", {ram_we, ram_addr, ram_wdata}, {1'b1, 8'h40, 16'h1111});
    chk("R9 stalled wr0", eng_stall_o, 2'b11);
    nxt();
    chk("R8 rd1 latched", {ram_we, ram_addr}, {1'b0, 8'h21});
    chk("R9 stalled rd1", eng_stall_o, 2'b11);
    nxt();
    chk("R7 wr1", {ram_we, ram_addr, ram_wdata, cpt_done_o}, {1'b1, 8'h41, 16'h5A5A, 1'b1});
    chk("R9 stalled wr1", eng_stall_o, 2'b11);
    @(negedge clk); eng_req = 2'b00; #1;
    chk("R7 busy clears", {cpt_busy_o, cpt_done_o}, 0);
    eng_op(0, 0, 8'h40, 0, rd, wt); chk("R7 param0 copied", rd, 16'h1111);
    eng_op(1, 0, 8'h41, 0, rd, wt); chk("R7 param1 copied", rd, 16'h5A5A);
    eng_op(0, 0, 8'hF1, 0, rd, wt); chk("R8 no stray write", rd === 16'h1111, 0);

    // alternation after fresh reset
    @(negedge clk); rst_ni = 0;
    repeat (2) @(negedge clk); rst_ni = 1;
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = 8'h40;
    cpt_req = 1; src0 = 8'h40; dst0 = 8'h50; src1 = 8'h41; dst1 = 8'h51;
    #1;
    chk("R10 host first after reset", {cpt_ack_o, host_gnt_o}, 0);
    nxt(); chk("R10 host granted", host_gnt_o, 1);
    nxt(); chk("R10 no ack in window", cpt_ack_o, 0);
    nxt(); chk("R10 coherent next", {cpt_ack_o, host_gnt_o}, 2'b10);
    nxt(); chk("R7 busy", cpt_busy_o, 1);
    nxt(); nxt(); nxt();
    chk("R7 done", cpt_done_o, 1);
    nxt(); chk("R10 host preferred again", cpt_ack_o, 0);
    nxt(); chk("R10 host granted again", host_gnt_o, 1);
    @(negedge clk); host_req = 0; cpt_req = 0;
    repeat (6) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule